// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is a serial-peripheral slave that takes 16-bit command words from a host controller and turns each one into a parallel command code and operand. The host drives a clock, a data line and an active-low select. All three are brought into the local system clock domain through two-flop synchronisers, and edges are detected there. The system clock must run at least four times faster than the serial clock.

A word is accepted when select is released after exactly sixteen rising serial-clock edges. The receiver then raises a one-cycle valid strobe and presents the upper four bits as the command code and the lower twelve as the operand. Any other bit count is dropped without a strobe. One command code, the set-configuration code, also loads an 8-bit mode register from the low operand bits. Other codes only strobe.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset is asserted, cmd_valid_o is 0, cmd_o and arg_o are 0 and mode_o is 0.
- R2: A frame of exactly 16 rising SCK edges while select is low produces exactly one cmd_valid_o pulse after select is released.
- R3: Bits are taken most significant first. The first 4 bits received form cmd_o and the next 12 form arg_o, with the first operand bit as arg_o[11].
- R4: A frame that ends with a bit count other than 16, whether shorter or longer, gives no cmd_valid_o pulse and changes neither mode_o nor cmd_o/arg_o.
- R5: When an accepted frame carries command code 4'h1 (set-configuration), mode_o takes arg_o[7:0] in the same cycle that cmd_valid_o is high. mode_o changes at no other time except reset.
- R6: cmd_valid_o is high for exactly one system clock cycle per accepted frame.
- R7: cmd_o and arg_o hold the values of the last accepted frame until the next accepted frame.
- R8: SCK edges that occur while select is high are ignored. They add no bits to the next frame and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host, idles low |
| mosi_i | input | 1 | Serial data from host |
| cs_ni | input | 1 | Active-low select; its release ends a frame |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted frame |
| cmd_o | output | 4 | Command code of the last accepted frame |
| arg_o | output | 12 | Operand of the last accepted frame |
| mode_o | output | 8 | Mode register, loaded by code 4'h1 |

## Verification
The hardest case to reach from the ports is a frame that is too long. In that case the shift register already holds sixteen plausible bits, and only the saturating bit counter keeps it from being accepted. The stimulus table therefore includes a 17-bit frame whose last sixteen bits form a valid set-configuration word. It also includes a 15-bit frame. Each one checks that no strobe appears and that the mode register and the held fields keep their previous values. A separate directed case toggles SCK while select is high just before a valid frame, so that stray edges would corrupt that frame if they were counted.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned CMD_W  = 4;
  localparam int unsigned ARG_W  = 12;
  localparam int unsigned MODE_W = 8;
  localparam int unsigned FRAME_W = CMD_W + ARG_W;
  localparam logic [CMD_W-1:0] SET_CFG_CODE = 4'h1;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_s_i,
  input  logic               mosi_s_i,
  input  logic               cs_s_i,   // synchronised, high = released
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned CNT_MAX = FRAME_W + 1;  // saturates: flags overlong
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             sck_q, cs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic             sck_rise, cs_release;

  assign sck_rise   = sck_s_i & ~sck_q & ~cs_s_i;
  assign cs_release = cs_s_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      sck_q <= sck_s_i;
      cs_q  <= cs_s_i;
      if (cs_s_i)
        cnt_q <= '0;
      else if (sck_rise && cnt_q != CNT_W'(CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
      if (sck_rise)
        sr_q <= {sr_q[FRAME_W-2:0], mosi_s_i};
    end
  end

  assign frame_vld_o = cs_release && (cnt_q == CNT_W'(FRAME_W));
  assign frame_o     = sr_q;
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               cmd_valid_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [ARG_W-1:0]   arg_o,
  output logic [MODE_W-1:0]  mode_o
);
  logic [CMD_W-1:0] code;
  logic [ARG_W-1:0] arg;

  assign code = frame_i[FRAME_W-1 -: CMD_W];
  assign arg  = frame_i[ARG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
      arg_o       <= '0;
      mode_o      <= '0;
    end else begin
      cmd_valid_o <= frame_vld_i;
      if (frame_vld_i) begin
        cmd_o <= code;
        arg_o <= arg;
        if (code == SET_CFG_CODE) mode_o <= arg[MODE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              cs_ni,
  output logic              cmd_valid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ARG_W-1:0]  arg_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [2:0] pins_s;
  logic       frame_vld;
  logic [FRAME_W-1:0] frame;

  spi_cmd_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, mosi_i, sck_i}),
    .q_o   (pins_s)
  );

  spi_cmd_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (pins_s[0]),
    .mosi_s_i   (pins_s[1]),
    .cs_s_i     (pins_s[2]),
    .frame_vld_o(frame_vld),
    .frame_o    (frame)
  );

  spi_cmd_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_vld_i(frame_vld),
    .frame_i    (frame),
    .cmd_valid_o(cmd_valid_o),
    .cmd_o      (cmd_o),
    .arg_o      (arg_o),
    .mode_o     (mode_o)
  );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk
  import spi_cmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [ARG_W-1:0]  arg_o,
  input logic [MODE_W-1:0] mode_o
);
  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o); // R6

  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == SET_CFG_CODE) |-> (mode_o == arg_o[MODE_W-1:0])); // R5

  AST_MODE_ONLY_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> (cmd_valid_o && cmd_o == SET_CFG_CODE)); // R5

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> ($stable(cmd_o) && $stable(arg_o))); // R7
endmodule

bind spi_cmd_rx spi_cmd_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_o(cmd_valid_o),
  .cmd_o      (cmd_o),
  .arg_o      (arg_o),
  .mode_o     (mode_o)
);

// File: tb/spi_cmd_rx_tb_top.sv
module spi_cmd_rx_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic        cmd_valid;
  logic [3:0]  cmd;
  logic [11:0] arg;
  logic [7:0]  mode;

  int errors = 0, checks = 0, pulses = 0, wide = 0, cycles = 0;
  logic prev_valid = 1'b0;
  logic [3:0]  exp_cmd  = '0;
  logic [11:0] exp_arg  = '0;
  logic [7:0]  exp_mode = '0;

  always #2 clk = ~clk;  // 250 MHz

  spi_cmd_rx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .mosi_i(mosi), .cs_ni(cs_n),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .arg_o(arg), .mode_o(mode)
  );

  // {nbits[4:0], word[15:0]}
  localparam logic [20:0] VEC [8] = '{
    {5'd16, 16'h10A5},
    {5'd16, 16'h2FFF},
    {5'd16, 16'h13C3},
    {5'd15, 16'h1055},
    {5'd17, 16'h1066},
    {5'd16, 16'hF123},
    {5'd16, 16'h0800},
    {5'd16, 16'h1FFF}
  };

  always @(negedge clk) begin
    cycles++;
    if (cmd_valid) pulses++;
    if (cmd_valid && prev_valid) wide++;
    prev_valid = cmd_valid;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [15:0] w);
    cs_n = 1'b0;
    wclk(3);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = (i < 16) ? w[i] : 1'b0;
      wclk(3);
      sck = 1'b1;
      wclk(3);
      sck = 1'b0;
    end
    wclk(3);
    cs_n = 1'b1;
    wclk(40);
  endtask

  initial begin
    wclk(5);
    chk(cmd_valid == 1'b0, "R1 valid", cmd_valid, 0);
    chk(mode == 8'h00, "R1 mode", mode, 0);
    chk(cmd == 4'h0 && arg == 12'h000, "R1 fields", {cmd, arg}, 0);
    rst_ni = 1'b1;
    wclk(5);

    for (int v = 0; v < 8; v++) begin
      int nb;
      logic [15:0] w;
      nb = int'(VEC[v][20:16]);
      w  = VEC[v][15:0];
      pulses = 0;
      send(nb, w);
      if (nb == 16) begin
        exp_cmd = w[15:12];
        exp_arg = w[11:0];
        if (w[15:12] == 4'h1) exp_mode = w[7:0];
        chk(pulses == 1, "R2 pulse count", pulses, 1);
        chk(cmd == exp_cmd, "R3 cmd", cmd, exp_cmd);
        chk(arg == exp_arg, "R3 arg", arg, exp_arg);
      end else begin
        chk(pulses == 0, "R4 bad length pulse", pulses, 0);
        chk({cmd, arg} == {exp_cmd, exp_arg}, "R7 hold", {cmd, arg}, {exp_cmd, exp_arg});
      end
      chk(mode == exp_mode, "R5 mode", mode, exp_mode);
    end

    // R8: stray SCK edges with select high, then a valid frame
    pulses = 0;
    for (int k = 0; k < 5; k++) begin
      sck = 1'b1; wclk(3); sck = 1'b0; wclk(3);
    end
    wclk(10);
    chk(pulses == 0, "R8 idle edges pulse", pulses, 0);
    chk(mode == exp_mode, "R8 idle edges mode", mode, exp_mode);
    send(16, 16'h1042);
    chk(pulses == 1, "R8 frame after idle edges", pulses, 1);
    chk(mode == 8'h42, "R8 mode", mode, 8'h42);

    chk(wide == 0, "R6 pulse width", wide, 0);

    // R1: reset mid-run clears mode
    rst_ni = 1'b0;
    wclk(2);
    chk(mode == 8'h00 && cmd_valid == 1'b0, "R1 reset clears", mode, 0);
    rst_ni = 1'b1;
    wclk(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule